// File: doc/BRIEF.md
# Boundary-Scan Test Access Port

This block is the serial test port of a memory device. A test controller drives a mode-select line and a data line, both sampled on the rising edge of the test clock. These walk a sixteen-state controller through the standard capture, shift and update phases for either the instruction path or the selected data path. There is no dedicated reset pin. A synchronous power-up reset, or five consecutive high samples of the mode-select line, returns the controller to its reset state. In that state the identification instruction becomes active.

The instruction register is three bits wide. The data register that sits between the serial input and output is chosen by the active instruction: a one-bit bypass cell, a 32-bit identification register, or a boundary register of parameterised length. The boundary register captures the device pins in parallel and, on update, presents a held copy that drives the outputs under the external-test instruction. Cells that map to no pin always capture 1. A separate instruction captures the pins while forcing every device output to high impedance. The serial output changes on the falling edge and is enabled only while a shift is in progress.

Top module: `bscan_tap`

## Requirements
- R1: After reset, and after any five consecutive rising edges with `tms` high from any state, the controller is in the reset state and the active instruction is the identification code 3'b001.
- R2: State transitions follow the standard 16-state test-port graph on `tms` sampled at the rising edge, including the pause and exit-2 paths and the return from select-IR to reset.
- R3: With the identification instruction active, a data shift returns the 32-bit `ID_CODE`, bit 0 first, and bit 0 is always 1.
- R4: Capture-IR loads 3'b001 into the instruction shift stage, so the first three bits shifted out of an instruction scan are 1, 0, 0.
- R5: A newly shifted instruction does not alter `out_hiz` or `bsr_drive` until the controller passes through Update-IR.
- R6: Opcodes decode as follows: 3'b000 external test (boundary register, `bsr_drive`=1), 3'b001 identification, 3'b010 sample with outputs forced off (boundary register, `out_hiz`=1), 3'b100 sample/preload (boundary register). 3'b011, 3'b101, 3'b110 and 3'b111 all select bypass.
- R7: The bypass cell captures 0 in Capture-DR and delays `tdi` by exactly one shift.
- R8: In Capture-DR, the boundary register loads `pin_in[i]` where `PIN_MASK[i]` is 1 and a constant 1 where it is 0. It shifts out bit 0 first.
- R9: `bsr_out` takes the boundary shift stage only in Update-DR while a boundary instruction is active, and holds otherwise.
- R10: `tdo` and `tdo_en` update on the falling edge of `tck`. `tdo_en` is 1 exactly while in Shift-IR or Shift-DR, and `tdo` is 0 outside a shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high power-up reset |
| tms | input | 1 | Mode select, sampled on rising edge |
| tdi | input | 1 | Serial data in, sampled on rising edge |
| pin_in | input | BSR_LEN | Device pin levels captured by the boundary register |
| tdo | output | 1 | Serial data out, updated on falling edge |
| tdo_en | output | 1 | Serial output driver enable |
| out_hiz | output | 1 | Forces all device outputs to high impedance |
| bsr_drive | output | 1 | Device outputs take `bsr_out` instead of core data |
| bsr_out | output | BSR_LEN | Update stage of the boundary register |

## Verification
The bench goes after the reserved opcodes. A decoder that treated them as boundary or identification access would return captured data instead of a 0-then-`tdi` stream. It also loads an instruction while another is active and checks the pin controls mid-scan. A design that applied the shift stage early would flip `out_hiz` or `bsr_drive` during Exit1-IR. Pause/exit-2 round trips and five-ones escapes from inside a shift check that the data already shifted is kept and that the instruction falls back to identification. Unmapped boundary cells are checked to read 1 regardless of the pin level.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

    localparam int IR_W = 3;
    localparam int ID_W = 32;

    typedef logic [IR_W-1:0] ir_t;

    localparam ir_t OP_EXTEST  = 3'b000;
    localparam ir_t OP_IDCODE  = 3'b001;
    localparam ir_t OP_SAMPZ   = 3'b010;
    localparam ir_t OP_SAMPPRE = 3'b100;

    typedef enum logic [3:0] {
        ST_TLR, ST_RTI,
        ST_SEL_DR, ST_CAP_DR, ST_SH_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SH_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_e;

    typedef enum logic [1:0] {DR_BYP, DR_ID, DR_BSR} dr_sel_e;

    typedef struct packed {
        logic tlr;
        logic cap_ir;
        logic sh_ir;
        logic upd_ir;
        logic cap_dr;
        logic sh_dr;
        logic upd_dr;
    } tap_ctl_t;

    function automatic tap_state_e tap_next(input tap_state_e s, input logic m);
        case (s)
            ST_TLR:    return m ? ST_TLR    : ST_RTI;
            ST_RTI:    return m ? ST_SEL_DR : ST_RTI;
            ST_SEL_DR: return m ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: return m ? ST_EX1_DR : ST_SH_DR;
            ST_SH_DR:  return m ? ST_EX1_DR : ST_SH_DR;
            ST_EX1_DR: return m ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: return m ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: return m ? ST_UPD_DR : ST_SH_DR;
            ST_UPD_DR: return m ? ST_SEL_DR : ST_RTI;
            ST_SEL_IR: return m ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR: return m ? ST_EX1_IR : ST_SH_IR;
            ST_SH_IR:  return m ? ST_EX1_IR : ST_SH_IR;
            ST_EX1_IR: return m ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: return m ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: return m ? ST_UPD_IR : ST_SH_IR;
            ST_UPD_IR: return m ? ST_SEL_DR : ST_RTI;
            default:   return ST_TLR;
        endcase
    endfunction

    function automatic dr_sel_e dr_decode(input ir_t op);
        case (op)
            OP_EXTEST, OP_SAMPZ, OP_SAMPPRE: return DR_BSR;
            OP_IDCODE:                       return DR_ID;
            default:                         return DR_BYP;
        endcase
    endfunction

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import bscan_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tms,
    output tap_state_e st,
    output tap_ctl_t   ctl
);
    tap_state_e st_q;

    always_ff @(posedge clk) begin
        if (rst) st_q <= ST_TLR;
        else     st_q <= tap_next(st_q, tms);
    end

    always_comb begin
        ctl        = '0;
        ctl.tlr    = (st_q == ST_TLR);
        ctl.cap_ir = (st_q == ST_CAP_IR);
        ctl.sh_ir  = (st_q == ST_SH_IR);
        ctl.upd_ir = (st_q == ST_UPD_IR);
        ctl.cap_dr = (st_q == ST_CAP_DR);
        ctl.sh_dr  = (st_q == ST_SH_DR);
        ctl.upd_dr = (st_q == ST_UPD_DR);
    end

    assign st = st_q;
endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import bscan_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  tap_ctl_t ctl,
    input  logic     tdi,
    output ir_t      ir_act,
    output logic     ir_lsb
);
    localparam ir_t CAP_PATTERN = ir_t'(2'b01);

    ir_t sh_q;
    ir_t act_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q  <= OP_IDCODE;
            act_q <= OP_IDCODE;
        end else begin
            if (ctl.cap_ir)     sh_q <= CAP_PATTERN;
            else if (ctl.sh_ir) sh_q <= {tdi, sh_q[IR_W-1:1]};

            if (ctl.tlr)         act_q <= OP_IDCODE;
            else if (ctl.upd_ir) act_q <= sh_q;
        end
    end

    assign ir_act = act_q;
    assign ir_lsb = sh_q[0];
endmodule

// File: rtl/tap_dr.sv
module tap_dr
    import bscan_pkg::*;
#(
    parameter int                BSR_LEN  = 8,
    parameter logic [ID_W-1:0]   ID_VAL   = 32'h0000_0001,
    parameter logic [BSR_LEN-1:0] PIN_MASK = '1
) (
    input  logic               clk,
    input  logic               rst,
    input  tap_ctl_t           ctl,
    input  dr_sel_e            sel,
    input  logic               tdi,
    input  logic [BSR_LEN-1:0] pin_in,
    output logic               byp_bit,
    output logic               dr_lsb,
    output logic [BSR_LEN-1:0] bsr_upd
);
    logic               byp_q;
    logic [ID_W-1:0]    id_q;
    logic [BSR_LEN-1:0] bs_q;
    logic [BSR_LEN-1:0] bu_q;
    logic [BSR_LEN-1:0] cap_vec;

    for (genvar i = 0; i < BSR_LEN; i++) begin : g_cell
        always_comb cap_vec[i] = PIN_MASK[i] ? pin_in[i] : 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            byp_q <= 1'b0;
            id_q  <= '0;
            bs_q  <= '0;
            bu_q  <= '0;
        end else begin
            if (ctl.cap_dr) begin
                case (sel)
                    DR_BYP:  byp_q <= 1'b0;
                    DR_ID:   id_q  <= ID_VAL;
                    DR_BSR:  bs_q  <= cap_vec;
                    default: byp_q <= 1'b0;
                endcase
            end else if (ctl.sh_dr) begin
                case (sel)
                    DR_BYP:  byp_q <= tdi;
                    DR_ID:   id_q  <= {tdi, id_q[ID_W-1:1]};
                    DR_BSR:  bs_q  <= {tdi, bs_q[BSR_LEN-1:1]};
                    default: byp_q <= tdi;
                endcase
            end
            if (ctl.upd_dr && sel == DR_BSR) bu_q <= bs_q;
        end
    end

    always_comb begin
        case (sel)
            DR_ID:   dr_lsb = id_q[0];
            DR_BSR:  dr_lsb = bs_q[0];
            default: dr_lsb = byp_q;
        endcase
    end

    assign byp_bit = byp_q;
    assign bsr_upd = bu_q;
endmodule

// File: rtl/bscan_tap.sv
module bscan_tap
    import bscan_pkg::*;
#(
    parameter int                 BSR_LEN  = 8,
    parameter logic [31:0]        ID_CODE  = 32'h1A5C_3E4D,
    parameter logic [BSR_LEN-1:0] PIN_MASK = 8'b1011_0111
) (
    input  logic               tck,
    input  logic               rst,
    input  logic               tms,
    input  logic               tdi,
    input  logic [BSR_LEN-1:0] pin_in,
    output logic               tdo,
    output logic               tdo_en,
    output logic               out_hiz,
    output logic               bsr_drive,
    output logic [BSR_LEN-1:0] bsr_out
);
    localparam logic [ID_W-1:0] ID_FIXED = {ID_CODE[ID_W-1:1], 1'b1};

    tap_state_e st_q;
    tap_ctl_t   ctl;
    ir_t        ir_act;
    logic       ir_lsb;
    dr_sel_e    dr_sel;
    logic       dr_lsb;
    logic       byp_bit;
    logic       sout;
    logic       tdo_q;
    logic       en_q;

    tap_fsm u_fsm (
        .clk (tck),
        .rst (rst),
        .tms (tms),
        .st  (st_q),
        .ctl (ctl)
    );

    tap_ir u_ir (
        .clk    (tck),
        .rst    (rst),
        .ctl    (ctl),
        .tdi    (tdi),
        .ir_act (ir_act),
        .ir_lsb (ir_lsb)
    );

    assign dr_sel = dr_decode(ir_act);

    tap_dr #(
        .BSR_LEN  (BSR_LEN),
        .ID_VAL   (ID_FIXED),
        .PIN_MASK (PIN_MASK)
    ) u_dr (
        .clk     (tck),
        .rst     (rst),
        .ctl     (ctl),
        .sel     (dr_sel),
        .tdi     (tdi),
        .pin_in  (pin_in),
        .byp_bit (byp_bit),
        .dr_lsb  (dr_lsb),
        .bsr_upd (bsr_out)
    );

    always_comb begin
        if (ctl.sh_ir)      sout = ir_lsb;
        else if (ctl.sh_dr) sout = dr_lsb;
        else                sout = 1'b0;
    end

    always_ff @(negedge tck) begin
        if (rst) begin
            tdo_q <= 1'b0;
            en_q  <= 1'b0;
        end else begin
            tdo_q <= sout;
            en_q  <= ctl.sh_ir | ctl.sh_dr;
        end
    end

    assign tdo       = tdo_q;
    assign tdo_en    = en_q;
    assign out_hiz   = (ir_act == OP_SAMPZ);
    assign bsr_drive = (ir_act == OP_EXTEST);
endmodule

// File: rtl/bscan_tap_chk.sv
module bscan_tap_chk
    import bscan_pkg::*;
#(
    parameter int BSR_LEN = 8
) (
    input logic               tck,
    input logic               rst,
    input logic               tms,
    input tap_state_e         st,
    input ir_t                ir_act,
    input dr_sel_e            sel,
    input logic               byp,
    input logic               tdo_en,
    input logic [BSR_LEN-1:0] bsr_out
);
    logic [2:0] ones_q;

    always_ff @(posedge tck) begin
        if (rst)                  ones_q <= 3'd5;
        else if (!tms)            ones_q <= 3'd0;
        else if (ones_q < 3'd5)   ones_q <= ones_q + 3'd1;
    end

    AST_FIVE_ONES_TLR: assert property (@(posedge tck) disable iff (rst)
        (ones_q == 3'd5) |-> (st == ST_TLR)); // R1

    AST_TLR_LOADS_ID: assert property (@(posedge tck) disable iff (rst)
        (st == ST_TLR) |=> (ir_act == OP_IDCODE)); // R1

    AST_IR_UPDATE_ONLY: assert property (@(posedge tck) disable iff (rst)
        (st != ST_UPD_IR && st != ST_TLR) |=> $stable(ir_act)); // R5

    AST_BYPASS_ZERO: assert property (@(posedge tck) disable iff (rst)
        (st == ST_CAP_DR && sel == DR_BYP) |=> (byp == 1'b0)); // R7

    AST_BSR_HOLD: assert property (@(posedge tck) disable iff (rst)
        !(st == ST_UPD_DR && sel == DR_BSR) |=> $stable(bsr_out)); // R9

    AST_TDOEN_SHIFT: assert property (@(posedge tck) disable iff (rst)
        tdo_en |-> (st == ST_SH_IR || st == ST_SH_DR)); // R10
endmodule

bind bscan_tap bscan_tap_chk #(.BSR_LEN(BSR_LEN)) u_chk (
    .tck     (tck),
    .rst     (rst),
    .tms     (tms),
    .st      (st_q),
    .ir_act  (ir_act),
    .sel     (dr_sel),
    .byp     (byp_bit),
    .tdo_en  (tdo_en),
    .bsr_out (bsr_out)
);

// File: tb/sim_bscan_tap.sv
module sim_bscan_tap;
    localparam int TCK_PERIOD = 10;
    localparam int BL = 8;
    localparam logic [31:0] IDV = 32'h1A5C_3E4D;
    localparam logic [BL-1:0] MASK = 8'b1011_0111;

    localparam int TLR = 0, RTI = 1, SDR = 2, CDR = 3, SHD = 4, E1D = 5, PDR = 6, E2D = 7,
                   UDR = 8, SIR = 9, CIR = 10, SHI = 11, E1I = 12, PIR = 13, E2I = 14, UIR = 15;

    logic tck = 1'b0;
    logic rst = 1'b1;
    logic tms = 1'b1;
    logic tdi = 1'b0;
    logic [BL-1:0] pin_in = '0;
    logic tdo, tdo_en, out_hiz, bsr_drive;
    logic [BL-1:0] bsr_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    int m_st;
    logic [2:0] m_irs, m_ira;
    logic m_byp;
    logic [31:0] m_id;
    logic [BL-1:0] m_bs, m_bu;
    logic last_tdo;

    bscan_tap #(.BSR_LEN(BL), .ID_CODE(IDV), .PIN_MASK(MASK)) u0 (
        .tck(tck), .rst(rst), .tms(tms), .tdi(tdi), .pin_in(pin_in),
        .tdo(tdo), .tdo_en(tdo_en), .out_hiz(out_hiz), .bsr_drive(bsr_drive),
        .bsr_out(bsr_out)
    );

    always #(TCK_PERIOD/2) tck = ~tck;

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int nxt(input int s, input logic m);
        case (s)
            TLR: return m ? TLR : RTI;
            RTI: return m ? SDR : RTI;
            SDR: return m ? SIR : CDR;
            CDR: return m ? E1D : SHD;
            SHD: return m ? E1D : SHD;
            E1D: return m ? UDR : PDR;
            PDR: return m ? E2D : PDR;
            E2D: return m ? UDR : SHD;
            UDR: return m ? SDR : RTI;
            SIR: return m ? TLR : CIR;
            CIR: return m ? E1I : SHI;
            SHI: return m ? E1I : SHI;
            E1I: return m ? UIR : PIR;
            PIR: return m ? E2I : PIR;
            E2I: return m ? UIR : SHI;
            default: return m ? SDR : RTI;
        endcase
    endfunction

    function automatic int msel();
        if (m_ira == 3'b000 || m_ira == 3'b010 || m_ira == 3'b100) return 2;
        if (m_ira == 3'b001) return 1;
        return 0;
    endfunction

    function automatic logic msout();
        if (m_st == SHI) return m_irs[0];
        if (m_st == SHD) begin
            case (msel())
                1: return m_id[0];
                2: return m_bs[0];
                default: return m_byp;
            endcase
        end
        return 1'b0;
    endfunction

    task automatic model_reset();
        m_st = TLR; m_irs = 3'b001; m_ira = 3'b001;
        m_byp = 0; m_id = '0; m_bs = '0; m_bu = '0;
    endtask

    task automatic model_edge(input logic t_ms, input logic t_di);
        int s;
        s = msel();
        case (m_st)
            TLR: m_ira = 3'b001;
            CIR: m_irs = 3'b001;
            SHI: m_irs = {t_di, m_irs[2:1]};
            UIR: m_ira = m_irs;
            CDR: begin
                if (s == 0) m_byp = 1'b0;
                else if (s == 1) m_id = IDV;
                else for (int i = 0; i < BL; i++) m_bs[i] = MASK[i] ? pin_in[i] : 1'b1;
            end
            SHD: begin
                if (s == 0) m_byp = t_di;
                else if (s == 1) m_id = {t_di, m_id[31:1]};
                else m_bs = {t_di, m_bs[BL-1:1]};
            end
            UDR: if (s == 2) m_bu = m_bs;
            default: ;
        endcase
        m_st = nxt(m_st, t_ms);
    endtask

    // R10 serial output timing, R6 pin controls, R9 update stage, every clock
    task automatic compare_all();
        chk("R10", "tdo_en", 64'(tdo_en), 64'(m_st == SHI || m_st == SHD));
        chk("R10", "tdo", 64'(tdo), 64'(msout()));
        chk("R6", "out_hiz", 64'(out_hiz), 64'(m_ira == 3'b010));
        chk("R6", "bsr_drive", 64'(bsr_drive), 64'(m_ira == 3'b000));
        chk("R9", "bsr_out", 64'(bsr_out), 64'(m_bu));
    endtask

    task automatic step(input logic t_ms, input logic t_di);
        tms = t_ms;
        tdi = t_di;
        @(posedge tck); #1;
        model_edge(t_ms, t_di);
        @(negedge tck); #1;
        compare_all();
        last_tdo = tdo;
    endtask

    task automatic load_ir(input logic [2:0] op, output logic [2:0] cap);
        logic h0, d0;
        h0 = out_hiz; d0 = bsr_drive;
        step(1, 0); step(1, 0); step(0, 0);
        step(0, 0); cap[0] = last_tdo;
        step(0, op[0]); cap[1] = last_tdo;
        step(0, op[1]); cap[2] = last_tdo;
        step(1, op[2]);
        chk("R5", "hiz held in Exit1-IR", 64'(out_hiz), 64'(h0));
        chk("R5", "drive held in Exit1-IR", 64'(bsr_drive), 64'(d0));
        step(1, 0);
        chk("R5", "drive held in Update-IR", 64'(bsr_drive), 64'(d0));
        step(0, 0);
    endtask

    task automatic shift_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
        dout = '0;
        step(1, 0); step(0, 0); step(0, 0);
        dout[0] = last_tdo;
        for (int i = 0; i < n; i++) begin
            step(i == n - 1, din[i]);
            if (i < n - 1) dout[i+1] = last_tdo;
        end
        step(1, 0); step(0, 0);
    endtask

    initial begin
        repeat (100000) @(posedge tck);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] o;
        logic [2:0] cap;
        logic [2:0] rsv [3];
        rsv[0] = 3'b011; rsv[1] = 3'b101; rsv[2] = 3'b110;
        model_reset();
        repeat (3) @(posedge tck);
        @(negedge tck); #1;
        rst = 0;
        chk("R1", "reset tdo_en", 64'(tdo_en), 0);
        chk("R1", "reset out_hiz", 64'(out_hiz), 0);
        chk("R1", "reset bsr_drive", 64'(bsr_drive), 0);
        chk("R1", "reset bsr_out", 64'(bsr_out), 0);

        step(0, 0);
        shift_dr(32, 64'h0, o);
        chk("R3", "idcode readout", o[31:0], 64'(IDV));
        chk("R3", "idcode lsb", 64'(o[0]), 1);

        load_ir(3'b111, cap);
        chk("R4", "capture-IR pattern", 64'(cap), 64'(3'b001));
        shift_dr(4, 64'b1101, o);
        chk("R7", "bypass delay", o[3:0], 64'(4'b1010));

        for (int k = 0; k < 3; k++) begin
            load_ir(rsv[k], cap);
            shift_dr(2, 64'b11, o);
            chk("R6", "reserved opcode selects bypass", o[1:0], 64'(2'b10));
        end

        pin_in = 8'hA5;
        load_ir(3'b100, cap);
        shift_dr(8, 64'h3C, o);
        chk("R8", "sample/preload capture", o[7:0], 64'hED);
        chk("R9", "preload update", 64'(bsr_out), 64'h3C);

        load_ir(3'b000, cap);
        chk("R6", "extest drive", 64'(bsr_drive), 1);
        chk("R9", "update held across IR load", 64'(bsr_out), 64'h3C);

        pin_in = 8'h0F;
        load_ir(3'b010, cap);
        chk("R6", "sample-z forces hiz", 64'(out_hiz), 1);
        chk("R6", "sample-z drive off", 64'(bsr_drive), 0);
        shift_dr(8, 64'h55, o);
        chk("R8", "sample-z capture", o[7:0], 64'h4F);
        chk("R9", "sample-z update", 64'(bsr_out), 64'h55);

        load_ir(3'b111, cap);
        step(1, 0); step(0, 0); step(0, 0);
        repeat (5) step(1, 0);
        step(0, 0);
        chk("R1", "five ones restore idcode", 64'(out_hiz), 0);

        step(1, 0); step(0, 0); step(0, 0);
        step(1, 0); step(0, 0); step(0, 0); step(1, 0); step(0, 0);
        chk("R2", "pause/exit2 resumes shift", 64'(last_tdo), 64'(IDV[1]));
        step(1, 0); step(1, 0); step(0, 0);

        step(1, 0); step(1, 0); step(0, 0); step(0, 0);
        step(1, 1); step(0, 0); step(1, 0); step(1, 0); step(0, 0);
        shift_dr(8, 64'h00, o);
        chk("R2", "IR pause path loads 100", o[7:0], 64'h4F);

        step(1, 0); step(1, 0); step(1, 0); step(0, 0);
        shift_dr(32, 64'h0, o);
        chk("R1", "select-IR escape resets IR", o[31:0], 64'(IDV));

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule